// File: doc/BRIEF.md
# Serial receiver frame-sync error detector

This block is the receive framing controller of a synchronous serial port. It runs on the bit clock, samples the serial data line on each rising edge, and starts a new element of `ELEM_W` bits when a frame-sync pulse is seen. The first data bit of the element is taken a programmable number of bit clocks (0, 1 or 2) after the pulse, and bits arrive MSB first. A completed element is copied to a holding register, a full flag is raised, and the receive interrupt pulses.

Each frame-sync pulse is classified against the element already in flight, including one that is still waiting out its data delay. A pulse whose first data bit would land on or before the last bit of that element is unexpected. A pulse that lands its first bit just after that last bit is normal, which allows back-to-back elements at the highest frame rate. With the ignore control set, an unexpected pulse is dropped and the current element finishes intact. With it clear, the partial element is thrown away, a new element starts from the offending pulse, and a sticky error bit is set. Software can write that bit to 0 or 1, and an interrupt-mode selector can route it to the interrupt output.

Top module: `serial_rx_framer`

## Requirements
- R1: After a frame-sync pulse sampled at edge t with delay d (0..2), the `ELEM_W` data bits are sampled MSB first at edges t+d through t+d+ELEM_W-1. After the last of these edges, `rdata_o` holds the element and `full_o` is 1.
- R2: A `delay_i` value of 2'b11 behaves exactly like 2'b10.
- R3: `full_o` clears on the edge after `rd_i` is sampled high. If an element completes on that same edge, `full_o` stays at 1.
- R4: When `int_mode_i` is not 2'b11, `irq_o` is high for exactly the one cycle that follows each completed element.
- R5: A pulse at edge t is unexpected only if an element is in flight and t+d is at or before that element's last bit edge L. A pulse at t = L+1-d is normal: both elements are received and no error is raised. A pulse one edge earlier is unexpected.
- R6: With `ignore_i` = 1, an unexpected pulse changes nothing. The element in flight completes with its original data, and `sync_err_o` is unchanged.
- R7: With `ignore_i` = 0, an unexpected pulse sets `sync_err_o`, discards the partial element, and starts a new element with delay d counted from that pulse.
- R8: `sync_err_o` is sticky. It clears only when `rx_en_i` = 0 or when software writes 0 (`err_wr_i` = 1, `err_wdata_i` = 0). A write of 1 sets it. A hardware set wins over a same-cycle write.
- R9: When `int_mode_i` = 2'b11, `irq_o` equals `sync_err_o` and gives no completion pulse.
- R10: While `rx_en_i` = 0, frame-sync pulses are ignored, and the element state, `full_o` and `sync_err_o` are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_en_i | input | 1 | Receiver enable; 0 holds the receiver in reset |
| fsync_i | input | 1 | Frame-sync pulse |
| data_i | input | 1 | Serial data line |
| delay_i | input | 2 | Data delay in bit clocks (3 acts as 2) |
| ignore_i | input | 1 | 1: drop unexpected frame-sync pulses |
| int_mode_i | input | 2 | 2'b11: interrupt follows error bit |
| rd_i | input | 1 | Holding register read strobe |
| err_wr_i | input | 1 | Write strobe for the error bit |
| err_wdata_i | input | 1 | Value written to the error bit |
| rdata_o | output | ELEM_W | Holding register |
| full_o | output | 1 | Holding register full |
| sync_err_o | output | 1 | Sticky frame-sync error |
| irq_o | output | 1 | Receive interrupt |

## Verification
The bench builds the block with `ELEM_W` = 8. At that length a pulse can be placed on every edge of the overlap window, so each delay value can be swept together with each pulse offset. The sweep covers the exact back-to-back position, the position one edge early, and a pulse well inside the element, each under both ignore settings. The expected holding value, error bit and pulse count come directly from where the pulses and bits were placed.

// File: rtl/srx_pkg.sv
package srx_pkg;
  typedef logic [1:0] dly_t;

  // delay code 3 is treated as the largest legal delay
  function automatic dly_t clamp_dly(input dly_t d);
    return (d == 2'd3) ? 2'd2 : d;
  endfunction
endpackage

// File: rtl/srx_classify.sv
module srx_classify #(
  parameter int ELEM_W = 8,
  localparam int BW = $clog2(ELEM_W + 1),
  localparam int SW = BW + 1
) (
  input  logic          en_i,
  input  logic          fsync_i,
  input  logic          ignore_i,
  input  srx_pkg::dly_t dly_i,
  input  logic          pend_i,
  input  logic [1:0]    pend_cnt_i,
  input  logic          active_i,
  input  logic [BW-1:0] left_i,
  output logic          accept_o,
  output logic          abort_o
);
  logic [SW-1:0] span;
  logic          unexp;

  // edges from now up to and including the last bit of the element in flight
  always_comb begin
    if (pend_i) span = SW'(pend_cnt_i) - SW'(1) + SW'(ELEM_W);
    else        span = SW'(left_i);
  end

  assign unexp    = (pend_i | active_i) & (SW'(dly_i) < span);
  assign accept_o = en_i & fsync_i & ~unexp;
  assign abort_o  = en_i & fsync_i & unexp & ~ignore_i;
endmodule

// File: rtl/srx_deser.sv
module srx_deser #(
  parameter int ELEM_W = 8,
  localparam int BW = $clog2(ELEM_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              data_i,
  input  srx_pkg::dly_t     dly_i,
  input  logic              accept_i,
  input  logic              abort_i,
  output logic              pend_o,
  output logic [1:0]        pend_cnt_o,
  output logic              active_o,
  output logic [BW-1:0]     left_o,
  output logic              done_o,
  output logic [ELEM_W-1:0] elem_o
);
  logic [ELEM_W-1:0] sr_q;
  logic [BW-1:0]     left_q;
  logic              act_q, pend_q;
  logic [1:0]        pcnt_q;
  logic              new_start, pend_fire, start_now;

  assign new_start = accept_i | abort_i;
  assign pend_fire = pend_q & (pcnt_q == 2'd1) & ~new_start;
  assign start_now = (new_start & (dly_i == 2'd0)) | pend_fire;
  assign elem_o    = {sr_q[ELEM_W-2:0], data_i};
  assign done_o    = en_i & act_q & ~abort_i & (left_q == BW'(1));

  assign pend_o     = pend_q;
  assign pend_cnt_o = pcnt_q;
  assign active_o   = act_q;
  assign left_o     = left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= '0;
      left_q <= '0;
      act_q  <= 1'b0;
      pend_q <= 1'b0;
      pcnt_q <= 2'd0;
    end else if (!en_i) begin
      act_q  <= 1'b0;
      pend_q <= 1'b0;
      left_q <= '0;
    end else begin
      if (new_start) begin
        pend_q <= (dly_i != 2'd0);
        pcnt_q <= dly_i;
      end else if (pend_q) begin
        pend_q <= (pcnt_q != 2'd1);
        pcnt_q <= pcnt_q - 2'd1;
      end

      if (start_now) begin
        sr_q   <= elem_o;
        left_q <= BW'(ELEM_W - 1);
        act_q  <= 1'b1;
      end else if (abort_i) begin
        act_q  <= 1'b0;
        left_q <= '0;
      end else if (act_q) begin
        sr_q   <= elem_o;
        left_q <= left_q - BW'(1);
        if (left_q == BW'(1)) act_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/srx_status.sv
module srx_status #(
  parameter int ELEM_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              done_i,
  input  logic [ELEM_W-1:0] elem_i,
  input  logic              abort_i,
  input  logic              rd_i,
  input  logic              err_wr_i,
  input  logic              err_wdata_i,
  input  logic [1:0]        int_mode_i,
  output logic [ELEM_W-1:0] rdata_o,
  output logic              full_o,
  output logic              err_o,
  output logic              irq_o
);
  logic [ELEM_W-1:0] hold_q;
  logic              full_q, err_q, done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      full_q <= 1'b0;
      err_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= done_i;
      if (done_i) hold_q <= elem_i;

      if (!en_i)       full_q <= 1'b0;
      else if (done_i) full_q <= 1'b1;
      else if (rd_i)   full_q <= 1'b0;

      // hardware set wins over a same-cycle software write
      if (!en_i)         err_q <= 1'b0;
      else if (abort_i)  err_q <= 1'b1;
      else if (err_wr_i) err_q <= err_wdata_i;
    end
  end

  assign rdata_o = hold_q;
  assign full_o  = full_q;
  assign err_o   = err_q;
  assign irq_o   = (int_mode_i == 2'b11) ? err_q : done_q;
endmodule

// File: rtl/serial_rx_framer.sv
module serial_rx_framer #(
  parameter int ELEM_W = 8,
  localparam int BW = $clog2(ELEM_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_en_i,
  input  logic              fsync_i,
  input  logic              data_i,
  input  logic [1:0]        delay_i,
  input  logic              ignore_i,
  input  logic [1:0]        int_mode_i,
  input  logic              rd_i,
  input  logic              err_wr_i,
  input  logic              err_wdata_i,
  output logic [ELEM_W-1:0] rdata_o,
  output logic              full_o,
  output logic              sync_err_o,
  output logic              irq_o
);
  srx_pkg::dly_t     dly;
  logic              accept, abort, pend, active, done;
  logic [1:0]        pend_cnt;
  logic [BW-1:0]     left;
  logic [ELEM_W-1:0] elem;

  assign dly = srx_pkg::clamp_dly(delay_i);

  srx_classify #(.ELEM_W(ELEM_W)) u_classify (
    .en_i      (rx_en_i),
    .fsync_i   (fsync_i),
    .ignore_i  (ignore_i),
    .dly_i     (dly),
    .pend_i    (pend),
    .pend_cnt_i(pend_cnt),
    .active_i  (active),
    .left_i    (left),
    .accept_o  (accept),
    .abort_o   (abort)
  );

  srx_deser #(.ELEM_W(ELEM_W)) u_deser (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (rx_en_i),
    .data_i    (data_i),
    .dly_i     (dly),
    .accept_i  (accept),
    .abort_i   (abort),
    .pend_o    (pend),
    .pend_cnt_o(pend_cnt),
    .active_o  (active),
    .left_o    (left),
    .done_o    (done),
    .elem_o    (elem)
  );

  srx_status #(.ELEM_W(ELEM_W)) u_status (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (rx_en_i),
    .done_i     (done),
    .elem_i     (elem),
    .abort_i    (abort),
    .rd_i       (rd_i),
    .err_wr_i   (err_wr_i),
    .err_wdata_i(err_wdata_i),
    .int_mode_i (int_mode_i),
    .rdata_o    (rdata_o),
    .full_o     (full_o),
    .err_o      (sync_err_o),
    .irq_o      (irq_o)
  );
endmodule

// File: rtl/srx_chk.sv
module srx_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       rx_en_i,
  input logic       fsync_i,
  input logic       ignore_i,
  input logic [1:0] int_mode_i,
  input logic       rd_i,
  input logic       err_wr_i,
  input logic       err_wdata_i,
  input logic       full_o,
  input logic       sync_err_o,
  input logic       irq_o
);
  // R3
  full_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(full_o) |-> ($past(rd_i) || !$past(rx_en_i)));

  // R4
  irq_pulse_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && int_mode_i != 2'b11) |-> full_o);

  // R7
  err_rise_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sync_err_o) |-> (($past(fsync_i) && !$past(ignore_i))
                           || ($past(err_wr_i) && $past(err_wdata_i))));

  // R6
  ignore_no_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ignore_i && !err_wr_i && !sync_err_o) |=> !sync_err_o);

  // R8
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_err_o && rx_en_i && !err_wr_i) |=> sync_err_o);

  // R10
  disabled_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_en_i |=> (!sync_err_o && !full_o));
endmodule

bind serial_rx_framer srx_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rx_en_i    (rx_en_i),
  .fsync_i    (fsync_i),
  .ignore_i   (ignore_i),
  .int_mode_i (int_mode_i),
  .rd_i       (rd_i),
  .err_wr_i   (err_wr_i),
  .err_wdata_i(err_wdata_i),
  .full_o     (full_o),
  .sync_err_o (sync_err_o),
  .irq_o      (irq_o)
);

// File: tb/serial_rx_framer_tb.sv
`timescale 1ns/1ps
module serial_rx_framer_tb;
  localparam int W = 8;
  localparam int N = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_en = 1'b0, fsync = 1'b0, data = 1'b0, ignore = 1'b0;
  logic rd = 1'b0, err_wr = 1'b0, err_wdata = 1'b0;
  logic [1:0] delay = 2'd0, int_mode = 2'd0;
  logic [W-1:0] rdata;
  logic full, sync_err, irq;

  logic fs_a [N];
  logic dat_a [N];
  int checks = 0, errors = 0, pulses = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  serial_rx_framer #(.ELEM_W(W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .rx_en_i(rx_en), .fsync_i(fsync),
    .data_i(data), .delay_i(delay), .ignore_i(ignore), .int_mode_i(int_mode),
    .rd_i(rd), .err_wr_i(err_wr), .err_wdata_i(err_wdata),
    .rdata_o(rdata), .full_o(full), .sync_err_o(sync_err), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic clear_sched();
    for (int i = 0; i < N; i++) begin
      fs_a[i] = 1'b0;
      dat_a[i] = 1'b0;
    end
  endtask

  // pulse at cycle c, bits MSB first from cycle c+d
  task automatic place(input int c, input int d, input logic [W-1:0] v);
    fs_a[c] = 1'b1;
    for (int i = 0; i < W; i++) dat_a[c+d+i] = v[W-1-i];
  endtask

  task automatic play();
    pulses = 0;
    for (int c = 0; c < N; c++) begin
      @(negedge clk);
      if (irq) pulses++;
      fsync = fs_a[c];
      data  = dat_a[c];
    end
    @(negedge clk);
    if (irq) pulses++;
    fsync = 1'b0;
    data  = 1'b0;
  endtask

  task automatic cleanup();
    @(negedge clk);
    rd = 1'b1; err_wr = 1'b1; err_wdata = 1'b0;
    @(negedge clk);
    rd = 1'b0; err_wr = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] v1, v2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 reset rdata", rdata, 0);
    chk("R10 reset full", full, 0);
    chk("R10 reset err", sync_err, 0);
    chk("R4 reset irq", irq, 0);
    rx_en = 1'b1;

    // R1 R3 R4: single element sweep over delay and value
    for (int d = 0; d < 3; d++) begin
      for (int k = 0; k < 4; k++) begin
        v1 = W'(37 * k + 91 * d + 17);
        delay = 2'(d);
        clear_sched(); place(0, d, v1); play();
        chk("R1 rdata", rdata, v1);
        chk("R1 full", full, 1);
        chk("R4 one pulse", pulses, 1);
        cleanup();
        chk("R3 full cleared by read", full, 0);
      end
    end

    // R2: code 3 behaves as delay 2
    delay = 2'd3;
    clear_sched(); place(0, 2, 8'hC3); play();
    chk("R2 rdata", rdata, 8'hC3);
    cleanup();

    // R3: read and completion in the same cycle keep full set
    delay = 2'd0;
    clear_sched(); place(0, 0, 8'h11); play();
    clear_sched(); place(0, 0, 8'h22);
    for (int c = 0; c < N; c++) begin
      @(negedge clk);
      fsync = fs_a[c]; data = dat_a[c];
      rd = (c == W - 1);
    end
    @(negedge clk); fsync = 1'b0; data = 1'b0; rd = 1'b0;
    chk("R3 full kept on same-cycle read", full, 1);
    chk("R3 new data", rdata, 8'h22);
    cleanup();

    // R5: back-to-back at max rate is normal; one edge early is unexpected
    for (int d = 0; d < 3; d++) begin
      delay = 2'(d); ignore = 1'b0;
      v1 = W'(8'h5A + d); v2 = W'(8'hA6 - d);
      clear_sched(); place(0, d, v1); place(W, d, v2); play();
      chk("R5 back-to-back err", sync_err, 0);
      chk("R5 back-to-back pulses", pulses, 2);
      chk("R5 back-to-back rdata", rdata, v2);
      cleanup();
      clear_sched(); place(0, d, v1); place(W - 1, d, v2); play();
      chk("R5 early err", sync_err, 1);
      chk("R7 early restart rdata", rdata, v2);
      chk("R7 early one pulse", pulses, 1);
      cleanup();
    end

    // R7: mid-element pulse, not ignored; R9 mode 3
    for (int d = 0; d < 3; d++) begin
      delay = 2'(d); ignore = 1'b0; int_mode = 2'b00;
      clear_sched(); place(0, d, 8'hF0); place(3, d, 8'h69); play();
      chk("R7 err set", sync_err, 1);
      chk("R7 restart rdata", rdata, 8'h69);
      chk("R7 discarded partial", pulses, 1);
      int_mode = 2'b11;
      @(negedge clk);
      chk("R9 irq follows err", irq, 1);
      int_mode = 2'b00;
      cleanup();
    end

    // R6: unexpected pulses ignored
    for (int d = 0; d < 3; d++) begin
      delay = 2'(d); ignore = 1'b1;
      clear_sched(); place(0, d, 8'h96); fs_a[3] = 1'b1; fs_a[W-1] = 1'b1; play();
      chk("R6 err unchanged", sync_err, 0);
      chk("R6 rdata intact", rdata, 8'h96);
      chk("R6 one pulse", pulses, 1);
      cleanup();
    end
    ignore = 1'b0;

    // R8: software access and stickiness
    delay = 2'd1;
    @(negedge clk); err_wr = 1'b1; err_wdata = 1'b1;
    @(negedge clk); err_wr = 1'b0;
    chk("R8 write 1 sets", sync_err, 1);
    clear_sched(); place(0, 1, 8'h3E); play();
    chk("R8 sticky through normal element", sync_err, 1);
    @(negedge clk); err_wr = 1'b1; err_wdata = 1'b0;
    @(negedge clk); err_wr = 1'b0;
    chk("R8 write 0 clears", sync_err, 0);
    // hardware set wins over same-cycle clear
    clear_sched(); place(0, 1, 8'h44); place(3, 1, 8'h55);
    for (int c = 0; c < N; c++) begin
      @(negedge clk);
      fsync = fs_a[c]; data = dat_a[c];
      err_wr = (c == 3); err_wdata = 1'b0;
    end
    @(negedge clk); fsync = 1'b0; data = 1'b0; err_wr = 1'b0;
    chk("R8 set beats write", sync_err, 1);
    @(negedge clk); rx_en = 1'b0;
    @(negedge clk); rx_en = 1'b1;
    chk("R8 R10 disable clears err", sync_err, 0);
    cleanup();

    // R9: mode 3 suppresses completion pulse
    int_mode = 2'b11;
    clear_sched(); place(0, 1, 8'h7B); play();
    chk("R9 no completion pulse", pulses, 0);
    chk("R9 data still received", rdata, 8'h7B);
    int_mode = 2'b00;
    cleanup();

    // R10: disabled receiver ignores pulses
    rx_en = 1'b0;
    clear_sched(); place(0, 1, 8'hE7); place(3, 1, 8'h18); play();
    chk("R10 no pulse", pulses, 0);
    chk("R10 full clear", full, 0);
    chk("R10 err clear", sync_err, 0);
    chk("R10 rdata held", rdata, 8'h7B);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule